// File: doc/BRIEF.md
# Outstanding Miss Table with Request Merging

This block tracks the cache misses that are waiting on the next level down. It is a small fully-associative table. Each cycle it looks at the request at the head of the miss queue and compares its block address with every live entry. It then gives one of three answers. It opens a new entry and forwards the request downstream. It folds the request into the entry already waiting on that address. Or it turns the request away, so that the head of the queue presents it again on a later cycle.

When the next level returns a block, the fill port marks the matching entry as returned and records the cycle at which its data becomes ready. Once the owning cache has consumed the entry, the retire port releases it. The retire port reads out everything the entry gathered: the block address, the request kind, the fill level, the destination flags for the instruction and data caches, the set of dependent queue slots, and the merged, returned and ready-cycle fields. A slot that is retired can be reused in the same cycle.

Kind encoding on `req_kind` and `ret_kind`: 0 = load, 1 = read-for-ownership, 2 = prefetch, 3 = instruction fetch. Load, read-for-ownership and instruction fetch are the demand kinds. A smaller fill level means a level closer to the core.

Top module: `mshr_table`

## Requirements
- R1: After reset the table holds no entries (`occupancy` = 0), `low_push` and `ret_valid` are 0, and every stall counter is 0.
- R2: A demand request with no live address match, and with a free slot, is accepted in the same cycle (`req_accept`=1). It takes the lowest-numbered free slot and raises `occupancy` by one. One cycle later it appears as `low_push`=1 with `low_addr` equal to its address and `low_pf`=0.
- R3: A request with no match while all N slots are live is stalled (`req_stall`=1). Nothing is pushed, and stall counter k, found at bits [k*CW +: CW] of `stall_cnt` where k is the request kind, goes up by one.
- R4: A demand request that matches a demand entry is accepted with no push and no new slot. The entry's fill level becomes the smaller of the two levels. Its destination flags become the OR of the two sets. The bit `req_dep` is set in its dependency set, and its merged flag is set.
- R5: An instruction-fetch request that matches a load or read-for-ownership entry, or a load or read-for-ownership request that matches an instruction-fetch entry, is a collision. It is stalled with no change to the entry and no change to any stall counter.
- R6: A demand request that matches a prefetch entry takes the entry over. The entry's kind becomes the request kind, and the R4 merge applies. The entry's returned flag and ready cycle keep the values they had before.
- R7: A prefetch request that matches any entry is accepted with no push. It changes only the entry's fill level (taking the minimum) and its destination flags (by OR). The kind, the dependency set and the merged flag stay as they were.
- R8: A prefetch request with no match is stalled while `low_full`=1. Otherwise it is accepted and pushed with `low_pf`=1. It occupies a slot only when `req_lvl` <= MY_LEVEL; otherwise it passes through without an entry.
- R9: With LAST_LEVEL=1, a demand request with no match is stalled while `low_full`=1, and no stall counter changes. A merge is still accepted while `low_full`=1.
- R10: A fill whose address matches a live entry sets that entry's returned flag and stores `fill_ready_at`. A fill that matches no live entry changes nothing.
- R11: A retire of a live slot frees it and, one cycle later, shows its contents on the `ret_*` outputs with `ret_valid`=1. In the cycle of the retire, the slot is already free for allocation and is no longer a match candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Head-of-queue request present |
| req_addr | input | AW | Block address of the request |
| req_kind | input | 2 | Request kind (0 load, 1 RFO, 2 prefetch, 3 instruction fetch) |
| req_lvl | input | LW | Level the block is to be filled to |
| req_to_i | input | 1 | Deliver the block to the instruction cache |
| req_to_d | input | 1 | Deliver the block to the data cache |
| req_dep | input | DW | Dependent queue slot index of a demand request |
| req_accept | output | 1 | Request handled this cycle |
| req_stall | output | 1 | Request refused; retry later |
| low_full | input | 1 | Lower-level request queue has no room |
| low_push | output | 1 | Registered push to the lower level |
| low_addr | output | AW | Address of the pushed request |
| low_pf | output | 1 | Pushed request is a prefetch |
| fill_valid | input | 1 | Block returned from below |
| fill_addr | input | AW | Address of the returned block |
| fill_ready_at | input | TW | Cycle at which the returned data is ready |
| retire_valid | input | 1 | Release a slot |
| retire_idx | input | IW | Slot to release |
| ret_valid | output | 1 | Retired entry contents valid |
| ret_addr | output | AW | Retired entry address |
| ret_kind | output | 2 | Retired entry kind |
| ret_lvl | output | LW | Retired entry fill level |
| ret_to_i | output | 1 | Retired entry instruction-cache flag |
| ret_to_d | output | 1 | Retired entry data-cache flag |
| ret_deps | output | DEPS | Retired entry dependency set |
| ret_merged | output | 1 | Retired entry took a demand merge |
| ret_returned | output | 1 | Retired entry had been filled |
| ret_ready_at | output | TW | Retired entry ready cycle |
| occupancy | output | IW+1 | Number of live slots |
| stall_cnt | output | 4*CW | Table-full stall counters, one per kind |

## Verification
The bench aims at the merge paths. A merge that overwrote the fill level instead of taking the minimum, or that dropped a destination flag, would show up in the retired contents. A demand takeover that cleared the returned flag or the ready cycle would also show up there, as would a prefetch merge that added dependency bits or changed the kind. Collisions are sent on purpose: a design that merged them would show an instruction flag on a load entry, and one that counted them would raise a stall counter. The bench separates table-full stalls from queue-full stalls through the counters. It also retires a slot in the same cycle as a request to the same address, which catches a design that still matches the dying entry or keeps the slot busy until the next cycle.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    K_LOAD   = 2'd0,
    K_RFO    = 2'd1,
    K_PREF   = 2'd2,
    K_IFETCH = 2'd3
  } req_kind_e;

  localparam int NUM_KINDS = 4;
endpackage

// File: rtl/mshr_match.sv
// Parallel address compare across all live slots.
module mshr_match #(
  parameter  int N  = 8,
  parameter  int AW = 20,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    live,
  input  logic [N*AW-1:0] tags,
  input  logic [AW-1:0]   key,
  output logic            hit,
  output logic [IW-1:0]   idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = live[g] && (tags[g*AW +: AW] == key);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (eq[i] && !hit) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_pick_free.sv
// Lowest-numbered free slot.
module mshr_pick_free #(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i] && !found) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_table.sv
module mshr_table
  import mshr_pkg::*;
#(
  parameter  int N          = 8,
  parameter  int AW         = 20,
  parameter  int LW         = 3,
  parameter  int DEPS       = 16,
  parameter  int TW         = 16,
  parameter  int CW         = 8,
  parameter  int MY_LEVEL   = 2,
  parameter  bit LAST_LEVEL = 1'b0,
  localparam int IW         = (N > 1) ? $clog2(N) : 1,
  localparam int DW         = (DEPS > 1) ? $clog2(DEPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_kind,
  input  logic [LW-1:0]     req_lvl,
  input  logic              req_to_i,
  input  logic              req_to_d,
  input  logic [DW-1:0]     req_dep,
  output logic              req_accept,
  output logic              req_stall,
  input  logic              low_full,
  output logic              low_push,
  output logic [AW-1:0]     low_addr,
  output logic              low_pf,
  input  logic              fill_valid,
  input  logic [AW-1:0]     fill_addr,
  input  logic [TW-1:0]     fill_ready_at,
  input  logic              retire_valid,
  input  logic [IW-1:0]     retire_idx,
  output logic              ret_valid,
  output logic [AW-1:0]     ret_addr,
  output logic [1:0]        ret_kind,
  output logic [LW-1:0]     ret_lvl,
  output logic              ret_to_i,
  output logic              ret_to_d,
  output logic [DEPS-1:0]   ret_deps,
  output logic              ret_merged,
  output logic              ret_returned,
  output logic [TW-1:0]     ret_ready_at,
  output logic [IW:0]       occupancy,
  output logic [4*CW-1:0]   stall_cnt
);
  // slot state
  logic [N-1:0]    v_q, ti_q, td_q, mrg_q, rtn_q;
  logic [AW-1:0]   tag_q [N];
  logic [1:0]      kind_q [N];
  logic [LW-1:0]   lvl_q [N];
  logic [DEPS-1:0] dep_q [N];
  logic [TW-1:0]   rdy_q [N];
  logic [CW-1:0]   scnt_q [NUM_KINDS];

  logic [N-1:0]    ret_mask, live, fill_hit, alloc_mask;
  logic [N*AW-1:0] tags_flat;
  logic            hit, free_found;
  logic [IW-1:0]   hidx, fidx;

  assign ret_mask = retire_valid ? (N'(1) << retire_idx) : '0;
  assign live     = v_q & ~ret_mask;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign tags_flat[g*AW +: AW] = tag_q[g];
    assign fill_hit[g] = fill_valid && live[g] && (tag_q[g] == fill_addr);
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_cnt
    assign stall_cnt[k*CW +: CW] = scnt_q[k];
  end

  mshr_match #(.N(N), .AW(AW)) u_match (
    .live(live), .tags(tags_flat), .key(req_addr), .hit(hit), .idx(hidx)
  );

  mshr_pick_free #(.N(N)) u_free (
    .busy(live), .found(free_found), .idx(fidx)
  );

  // request classification
  logic            req_pf, req_ins, ent_ins, ent_pf, collide;
  logic [LW-1:0]   merged_lvl;
  logic [DEPS-1:0] dep_bit;

  assign req_pf     = (req_kind == K_PREF);
  assign req_ins    = (req_kind == K_IFETCH);
  assign ent_pf     = (kind_q[hidx] == K_PREF);
  assign ent_ins    = (kind_q[hidx] == K_IFETCH);
  assign collide    = hit && !req_pf && !ent_pf && (req_ins != ent_ins);
  assign merged_lvl = (req_lvl < lvl_q[hidx]) ? req_lvl : lvl_q[hidx];
  assign dep_bit    = DEPS'(1) << req_dep;

  logic do_alloc, do_merge, do_push, full_stall;

  always_comb begin
    req_accept = 1'b0;
    req_stall  = 1'b0;
    do_alloc   = 1'b0;
    do_merge   = 1'b0;
    do_push    = 1'b0;
    full_stall = 1'b0;
    if (req_valid) begin
      if (collide) begin
        req_stall = 1'b1;
      end else if (hit) begin
        req_accept = 1'b1;
        do_merge   = 1'b1;
      end else if (!free_found) begin
        req_stall  = 1'b1;
        full_stall = 1'b1;
      end else if (req_pf) begin
        if (low_full) begin
          req_stall = 1'b1;
        end else begin
          req_accept = 1'b1;
          do_push    = 1'b1;
          do_alloc   = (int'(req_lvl) <= MY_LEVEL);
        end
      end else if (LAST_LEVEL && low_full) begin
        req_stall = 1'b1;
      end else begin
        req_accept = 1'b1;
        do_push    = 1'b1;
        do_alloc   = 1'b1;
      end
    end
  end

  assign alloc_mask = do_alloc ? (N'(1) << fidx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else begin
      v_q <= (v_q & ~ret_mask) | alloc_mask;
    end
  end

  // slot payload, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (alloc_mask[i]) begin
        tag_q[i]  <= req_addr;
        kind_q[i] <= req_kind;
        lvl_q[i]  <= req_lvl;
        ti_q[i]   <= req_to_i;
        td_q[i]   <= req_to_d;
        dep_q[i]  <= req_pf ? '0 : dep_bit;
        mrg_q[i]  <= 1'b0;
        rtn_q[i]  <= 1'b0;
        rdy_q[i]  <= '0;
      end else begin
        if (do_merge && (hidx == IW'(i))) begin
          lvl_q[i] <= merged_lvl;
          ti_q[i]  <= ti_q[i] | req_to_i;
          td_q[i]  <= td_q[i] | req_to_d;
          if (!req_pf) begin
            dep_q[i] <= dep_q[i] | dep_bit;
            mrg_q[i] <= 1'b1;
            if (kind_q[i] == K_PREF) kind_q[i] <= req_kind;
          end
        end
        if (fill_hit[i]) begin
          rtn_q[i] <= 1'b1;
          rdy_q[i] <= fill_ready_at;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_push  <= 1'b0;
      low_addr  <= '0;
      low_pf    <= 1'b0;
      ret_valid <= 1'b0;
      ret_addr  <= '0;
      ret_kind  <= '0;
      ret_lvl   <= '0;
      ret_to_i  <= 1'b0;
      ret_to_d  <= 1'b0;
      ret_deps  <= '0;
      ret_merged   <= 1'b0;
      ret_returned <= 1'b0;
      ret_ready_at <= '0;
      for (int k = 0; k < NUM_KINDS; k++) scnt_q[k] <= '0;
    end else begin
      low_push  <= do_push;
      low_addr  <= req_addr;
      low_pf    <= req_pf;
      ret_valid <= retire_valid && v_q[retire_idx];
      ret_addr  <= tag_q[retire_idx];
      ret_kind  <= kind_q[retire_idx];
      ret_lvl   <= lvl_q[retire_idx];
      ret_to_i  <= ti_q[retire_idx];
      ret_to_d  <= td_q[retire_idx];
      ret_deps  <= dep_q[retire_idx];
      ret_merged   <= mrg_q[retire_idx];
      ret_returned <= rtn_q[retire_idx];
      ret_ready_at <= rdy_q[retire_idx];
      if (full_stall) scnt_q[req_kind] <= scnt_q[req_kind] + CW'(1);
    end
  end

  always_comb begin
    occupancy = '0;
    for (int i = 0; i < N; i++) occupancy = occupancy + (IW+1)'(v_q[i]);
  end
endmodule

// File: rtl/mshr_table_chk.sv
module mshr_table_chk #(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_accept,
  input logic       req_stall,
  input logic       low_full,
  input logic       low_push,
  input logic       low_pf,
  input logic       retire_valid,
  input logic       ret_valid,
  input logic [IW:0] occupancy
);
  p_one_answer_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_accept != req_stall));

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!req_accept && !req_stall));

  p_push_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    low_push |-> $past(req_valid && req_accept));

  p_pf_push_room_r8: assert property (@(posedge clk) disable iff (rst)
    (low_push && low_pf) |-> !$past(low_full));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) <= N);

  p_grow_by_one_r2: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) <= int'($past(occupancy)) + 1);

  p_ret_after_cmd_r11: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(retire_valid));
endmodule

bind mshr_table mshr_table_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_accept(req_accept),
  .req_stall(req_stall), .low_full(low_full), .low_push(low_push),
  .low_pf(low_pf), .retire_valid(retire_valid), .ret_valid(ret_valid),
  .occupancy(occupancy)
);

// File: tb/tb_mshr_table.sv
module tb_mshr_table;
  localparam int N = 4, AW = 16, LW = 3, DEPS = 8, TW = 16, CW = 8;
  localparam int IW = 2, DW = 3;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_to_i = 0, req_to_d = 0;
  logic [AW-1:0] req_addr = 0;
  logic [1:0] req_kind = 0;
  logic [LW-1:0] req_lvl = 0;
  logic [DW-1:0] req_dep = 0;
  logic req_accept, req_stall;
  logic low_full = 0, low_push, low_pf;
  logic [AW-1:0] low_addr;
  logic fill_valid = 0;
  logic [AW-1:0] fill_addr = 0;
  logic [TW-1:0] fill_ready_at = 0;
  logic retire_valid = 0;
  logic [IW-1:0] retire_idx = 0;
  logic ret_valid, ret_to_i, ret_to_d, ret_merged, ret_returned;
  logic [AW-1:0] ret_addr;
  logic [1:0] ret_kind;
  logic [LW-1:0] ret_lvl;
  logic [DEPS-1:0] ret_deps;
  logic [TW-1:0] ret_ready_at;
  logic [IW:0] occupancy;
  logic [4*CW-1:0] stall_cnt;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  mshr_table #(.N(N), .AW(AW), .LW(LW), .DEPS(DEPS), .TW(TW), .CW(CW),
               .MY_LEVEL(2), .LAST_LEVEL(1'b1)) dut (.*);

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // present one request for one cycle; checks the immediate answer and the push
  task automatic send(string tag, logic [AW-1:0] a, logic [1:0] k, logic [LW-1:0] l,
                      logic ti, logic td, logic [DW-1:0] d, logic exp_acc, logic exp_push);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_kind = k; req_lvl = l;
    req_to_i = ti; req_to_d = td; req_dep = d;
    #1 chk({tag, " accept"}, req_accept, exp_acc);
    chk({tag, " stall"}, req_stall, !exp_acc);
    @(posedge clk); #1;
    req_valid = 0;
    chk({tag, " push"}, low_push, exp_push);
    if (exp_push) chk({tag, " push addr"}, low_addr, a);
  endtask

  task automatic retire(logic [IW-1:0] idx);
    @(negedge clk);
    retire_valid = 1; retire_idx = idx;
    @(posedge clk); #1;
    retire_valid = 0;
  endtask

  task automatic fill(logic [AW-1:0] a, logic [TW-1:0] t);
    @(negedge clk);
    fill_valid = 1; fill_addr = a; fill_ready_at = t;
    @(posedge clk); #1;
    fill_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 occupancy", occupancy, 0);
    chk("R1 push", low_push, 0);
    chk("R1 ret_valid", ret_valid, 0);
    chk("R1 counters", stall_cnt, 0);
  endtask

  task automatic t_alloc_merge_collide();
    send("R2 new load", 16'h100, 2'd0, 3'd2, 0, 1, 3'd2, 1, 1);
    chk("R2 push kind", low_pf, 0);
    chk("R2 occupancy", occupancy, 1);
    send("R4 rfo merge", 16'h100, 2'd1, 3'd1, 1, 0, 3'd5, 1, 0);
    chk("R4 occupancy", occupancy, 1);
    send("R5 ifetch collide", 16'h100, 2'd3, 3'd0, 1, 0, 3'd7, 0, 0);
    chk("R5 counter", stall_cnt[3*CW +: CW], 0);
    retire(0);
    chk("R11 ret_valid", ret_valid, 1);
    chk("R11 addr", ret_addr, 16'h100);
    chk("R4 kind kept", ret_kind, 0);
    chk("R4 min lvl", ret_lvl, 1);
    chk("R4 to_i", ret_to_i, 1);
    chk("R4 to_d", ret_to_d, 1);
    chk("R4 deps", ret_deps, 8'h24);
    chk("R4 merged", ret_merged, 1);
    chk("R11 occupancy", occupancy, 0);
  endtask

  task automatic t_takeover();
    send("R8 pf alloc", 16'h200, 2'd2, 3'd2, 0, 0, 3'd0, 1, 1);
    chk("R8 pf flag", low_pf, 1);
    chk("R8 occupancy", occupancy, 1);
    fill(16'h200, 16'h55);
    send("R6 load over pf", 16'h200, 2'd0, 3'd3, 0, 1, 3'd1, 1, 0);
    retire(0);
    chk("R6 kind", ret_kind, 0);
    chk("R6 returned kept", ret_returned, 1);
    chk("R10 ready kept", ret_ready_at, 16'h55);
    chk("R6 lvl", ret_lvl, 2);
    chk("R6 deps", ret_deps, 8'h02);
    chk("R6 merged", ret_merged, 1);
  endtask

  task automatic t_pf_merge();
    send("R7 pf alloc", 16'h300, 2'd2, 3'd2, 0, 0, 3'd0, 1, 1);
    send("R7 pf merge", 16'h300, 2'd2, 3'd1, 1, 0, 3'd4, 1, 0);
    retire(0);
    chk("R7 kind", ret_kind, 2);
    chk("R7 lvl", ret_lvl, 1);
    chk("R7 to_i", ret_to_i, 1);
    chk("R7 deps", ret_deps, 0);
    chk("R7 merged", ret_merged, 0);
  endtask

  task automatic t_pf_pass_and_full_queue();
    send("R8 pf pass", 16'h400, 2'd2, 3'd3, 0, 0, 3'd0, 1, 1);
    chk("R8 pass flag", low_pf, 1);
    chk("R8 no entry", occupancy, 0);
    low_full = 1;
    send("R8 pf blocked", 16'h500, 2'd2, 3'd2, 0, 0, 3'd0, 0, 0);
    send("R9 demand blocked", 16'h600, 2'd0, 3'd1, 0, 1, 3'd0, 0, 0);
    chk("R9 counter", stall_cnt, 0);
    chk("R9 occupancy", occupancy, 0);
    low_full = 0;
  endtask

  task automatic t_full_and_reuse();
    for (int i = 0; i < N; i++)
      send("R2 fill up", AW'(16'h10 + i), 2'd0, 3'd2, 0, 1, DW'(i), 1, 1);
    chk("R2 full occupancy", occupancy, 4);
    send("R3 load full", 16'h14, 2'd0, 3'd2, 0, 1, 3'd0, 0, 0);
    chk("R3 load counter", stall_cnt[0 +: CW], 1);
    send("R3 rfo full", 16'h15, 2'd1, 3'd2, 0, 1, 3'd0, 0, 0);
    chk("R3 rfo counter", stall_cnt[1*CW +: CW], 1);
    low_full = 1;
    send("R9 merge while full", 16'h12, 2'd0, 3'd2, 0, 1, 3'd6, 1, 0);
    low_full = 0;
    fill(16'h999, 16'h77);
    // R11: retire slot 1 while a request names its address in the same cycle
    @(negedge clk);
    retire_valid = 1; retire_idx = 1;
    req_valid = 1; req_addr = 16'h11; req_kind = 2'd0; req_lvl = 3'd2;
    req_to_i = 0; req_to_d = 1; req_dep = 3'd7;
    #1 chk("R11 reuse accept", req_accept, 1);
    @(posedge clk); #1;
    retire_valid = 0; req_valid = 0;
    chk("R11 reuse push", low_push, 1);
    chk("R11 old contents", ret_deps, 8'h02);
    chk("R11 occupancy", occupancy, 4);
    retire(1);
    chk("R11 new deps", ret_deps, 8'h80);
    chk("R11 new merged", ret_merged, 0);
    retire(0);
    chk("R10 stray fill", ret_returned, 0);
    retire(2);
    chk("R4 full merge deps", ret_deps, 8'h44);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_alloc_merge_collide();
    t_takeover();
    t_pf_merge();
    t_pf_pass_and_full_queue();
    t_full_and_reuse();
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule